// File: doc/BRIEF.md
# Two-Channel Pixel Word Serializer with Framing

This block takes two 14-bit sample words per pixel and shifts them out, one bit per enabled bit-clock cycle, on four single-bit lanes. It runs on one fast clock with a bit-rate enable (`bit_en`). Every enabled cycle advances a slot counter. The pixel boundary is the enabled cycle that starts a new word. On that boundary both channel words and the lane mode are captured together.

The block has two lane modes. In two-lane mode each channel uses one lane, and its 14-bit word goes out MSB first over 14 slots. In four-lane mode each channel is split over two lanes, one lane carrying the upper seven bits and the other the lower seven. Four-lane mode uses eight slots per pixel, and the eighth slot repeats the last data bit.

A frame bit rises with the first bit of every word. The slot in which it falls tells the receiver whether the word is tagged odd or even, and the tags alternate from word to word. A one-cycle bit strobe tells a downstream output stage where each new bit begins, so that it can place the forwarded clock edge in the middle of the bit.

Top module: `pxser_top`

## Requirements
- R1: With `quad_mode`=1 captured, each word spans 8 slots (0..7). Lane 1 carries ch1 bits 13..7 and lane 0 carries ch1 bits 6..0, both MSB first, one bit per slot. Lanes 2 and 3 carry the same split of ch2. In slot 7 every lane repeats the bit it had in slot 6.
- R2: With `quad_mode`=0 captured, each word spans 14 slots, and slot k carries bit 13-k. Lane 1 carries ch1 and lane 2 carries ch2. Lanes 0 and 3 output 0. `lane_en` (bit i = lane i) is 4'b0110 in this mode and 4'b1111 in four-lane mode.
- R3: `frame_bit` is 1 only in the first slots of a word: slots 0..2 for an odd-tagged word, slots 0..1 for an even-tagged word. It is 0 in all other slots, so it rises exactly at each word start.
- R4: `tag_odd` is 1 for the first word after reset and inverts at every following word start.
- R5: Both words are sampled only in the enabled cycle that starts a word. Input changes at any other time do not change the bits shifted out.
- R6: `quad_mode` is sampled only at a word start. A change in the middle of a word does not change that word's slot count or lane mapping.
- R7: In a cycle with `bit_en`=0, the lanes, `frame_bit` and `tag_odd` keep their values.
- R8: `bit_strobe` is 1 in exactly those cycles that follow a cycle with `bit_en`=1.
- R9: While and after reset, until the first enabled cycle: lanes 0, `frame_bit` 0, `tag_odd` 0, `lane_en` 4'b0110, `bit_strobe` 0. The first enabled cycle after reset starts a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit-slot enable; one slot per enabled cycle |
| quad_mode | input | 1 | 1 = four-lane split, 0 = two-lane; taken at word start |
| ch1_word | input | 14 | Channel 1 sample |
| ch2_word | input | 14 | Channel 2 sample |
| lane_bit | output | 4 | Serial bit per lane |
| lane_en | output | 4 | Lane driven flag per lane |
| frame_bit | output | 1 | Pixel frame, falling slot encodes tag |
| tag_odd | output | 1 | 1 when the current word is tagged odd |
| bit_strobe | output | 1 | Marks the first cycle of each new bit |

## Verification
Every registered result changes on the clock edge that samples `bit_en` high. The lane bits, frame, tag and lane enables of a new slot can be seen in the same cycle after that edge. `bit_strobe` is high in that cycle and drops one cycle after `bit_en` drops. The bench's model takes a step on each rising edge using the same inputs the design sees, and every output is compared on the falling edge that follows, so each result is checked in the first cycle it is due. Random enable gaps, mid-word mode flips and words that change every cycle move the capture points around, which tests R5 to R7 against the model's own slot count.

// File: rtl/pxser_pkg.sv
package pxser_pkg;

    typedef enum logic {
        LANES_TWO  = 1'b0,
        LANES_FOUR = 1'b1
    } lane_mode_e;

    // Slot in which the frame drops for each tag (first slot low).
    localparam int FALL_SLOT_ODD  = 3;
    localparam int FALL_SLOT_EVEN = 2;

    typedef struct packed {
        logic       idle;
        logic       tag_odd;
        lane_mode_e mode;
    } seq_state_t;

    function automatic logic frame_level(input logic idle, input logic odd, input int slot);
        int fall;
        fall = odd ? FALL_SLOT_ODD : FALL_SLOT_EVEN;
        return !idle && (slot < fall);
    endfunction

endpackage

// File: rtl/pxser_slot_seq.sv
module pxser_slot_seq
    import pxser_pkg::*;
#(
    parameter int TWO_SLOTS  = 14,
    parameter int FOUR_SLOTS = 8,
    parameter int SLOT_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  lane_mode_e        mode_req,
    output logic [SLOT_W-1:0] slot,
    output seq_state_t        st,
    output logic              load
);
    localparam logic [SLOT_W-1:0] LAST_TWO  = SLOT_W'(TWO_SLOTS - 1);
    localparam logic [SLOT_W-1:0] LAST_FOUR = SLOT_W'(FOUR_SLOTS - 1);

    logic [SLOT_W-1:0] last_slot;

    assign last_slot = (st.mode == LANES_FOUR) ? LAST_FOUR : LAST_TWO;
    assign load      = bit_en && (st.idle || slot == last_slot);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot       <= '0;
            st.idle    <= 1'b1;
            st.tag_odd <= 1'b0;
            st.mode    <= LANES_TWO;
        end else if (load) begin
            slot       <= '0;
            st.idle    <= 1'b0;
            st.tag_odd <= ~st.tag_odd;
            st.mode    <= mode_req;
        end else if (bit_en) begin
            slot <= slot + 1'b1;
        end
    end

endmodule

// File: rtl/pxser_word_hold.sv
module pxser_word_hold #(
    parameter int WORD_W = 14,
    parameter int CHANS  = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         load,
    input  logic [CHANS-1:0][WORD_W-1:0] word_in,
    output logic [CHANS-1:0][WORD_W-1:0] word_q
);
    for (genvar c = 0; c < CHANS; c++) begin : g_hold
        always_ff @(posedge clk) begin
            if (rst)       word_q[c] <= '0;
            else if (load) word_q[c] <= word_in[c];
        end
    end
endmodule

// File: rtl/pxser_lane_mux.sv
module pxser_lane_mux
    import pxser_pkg::*;
#(
    parameter int WORD_W = 14,
    parameter int SLOT_W = 4
) (
    input  logic [SLOT_W-1:0]    slot,
    input  seq_state_t           st,
    input  logic [1:0][WORD_W-1:0] word_q,
    output logic [3:0]           lane_bit,
    output logic [3:0]           lane_en,
    output logic                 frame_bit
);
    localparam int HALF = WORD_W / 2;

    logic four;
    logic [SLOT_W-1:0] split_idx;

    assign four      = (st.mode == LANES_FOUR);
    assign split_idx = (int'(slot) >= HALF) ? SLOT_W'(HALF - 1) : slot;
    assign lane_en   = four ? 4'b1111 : 4'b0110;
    assign frame_bit = frame_level(st.idle, st.tag_odd, int'(slot));

    // Channel c: upper lane is 1+c, lower lane is 3*c.
    for (genvar c = 0; c < 2; c++) begin : g_chan
        logic upper_b;
        logic lower_b;
        always_comb begin
            if (four) begin
                upper_b = word_q[c][WORD_W - 1 - int'(split_idx)];
                lower_b = word_q[c][HALF - 1 - int'(split_idx)];
            end else begin
                upper_b = word_q[c][WORD_W - 1 - int'(slot)];
                lower_b = 1'b0;
            end
        end
        assign lane_bit[1 + c] = upper_b;
        assign lane_bit[3 * c] = lower_b;
    end
endmodule

// File: rtl/pxser_top.sv
module pxser_top
    import pxser_pkg::*;
#(
    parameter int WORD_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              quad_mode,
    input  logic [WORD_W-1:0] ch1_word,
    input  logic [WORD_W-1:0] ch2_word,
    output logic [3:0]        lane_bit,
    output logic [3:0]        lane_en,
    output logic              frame_bit,
    output logic              tag_odd,
    output logic              bit_strobe
);
    localparam int HALF       = WORD_W / 2;
    localparam int FOUR_SLOTS = HALF + 1;
    localparam int TWO_SLOTS  = WORD_W;
    localparam int SLOT_W     = $clog2(TWO_SLOTS);

    logic [SLOT_W-1:0]      slot;
    seq_state_t             st;
    logic                   load;
    logic [1:0][WORD_W-1:0] word_q;
    lane_mode_e             mode_req;

    assign mode_req = lane_mode_e'(quad_mode);

    pxser_slot_seq #(
        .TWO_SLOTS (TWO_SLOTS),
        .FOUR_SLOTS(FOUR_SLOTS),
        .SLOT_W    (SLOT_W)
    ) seq_i (
        .clk     (clk),
        .rst     (rst),
        .bit_en  (bit_en),
        .mode_req(mode_req),
        .slot    (slot),
        .st      (st),
        .load    (load)
    );

    pxser_word_hold #(
        .WORD_W(WORD_W),
        .CHANS (2)
    ) hold_i (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .word_in({ch2_word, ch1_word}),
        .word_q (word_q)
    );

    pxser_lane_mux #(
        .WORD_W(WORD_W),
        .SLOT_W(SLOT_W)
    ) mux_i (
        .slot     (slot),
        .st       (st),
        .word_q   (word_q),
        .lane_bit (lane_bit),
        .lane_en  (lane_en),
        .frame_bit(frame_bit)
    );

    assign tag_odd = st.tag_odd;

    always_ff @(posedge clk) begin
        if (rst) bit_strobe <= 1'b0;
        else     bit_strobe <= bit_en;
    end

endmodule

// File: rtl/pxser_chk.sv
module pxser_chk (
    input logic       clk,
    input logic       rst,
    input logic       bit_en,
    input logic [3:0] lane_bit,
    input logic [3:0] lane_en,
    input logic       frame_bit,
    input logic       tag_odd,
    input logic       bit_strobe
);
    a_r3_rise_on_enabled_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_bit) |-> $past(bit_en));

    a_r4_tag_flips_at_start: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_bit) |-> (tag_odd != $past(tag_odd)));

    a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> ($stable(lane_bit) && $stable(frame_bit) && $stable(tag_odd)));

    a_r8_strobe_follows_en: assert property (@(posedge clk) disable iff (rst)
        bit_en |=> bit_strobe);

    a_r8_strobe_low_after_gap: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> !bit_strobe);

    a_r2_unused_lanes_quiet: assert property (@(posedge clk) disable iff (rst)
        !lane_en[0] |-> (lane_bit[0] == 1'b0 && lane_bit[3] == 1'b0));

    a_r2_enable_patterns: assert property (@(posedge clk) disable iff (rst)
        (lane_en == 4'b0110) || (lane_en == 4'b1111));
endmodule

bind pxser_top pxser_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .lane_bit  (lane_bit),
    .lane_en   (lane_en),
    .frame_bit (frame_bit),
    .tag_odd   (tag_odd),
    .bit_strobe(bit_strobe)
);

// File: tb/pxser_top_tb_top.sv
`timescale 1ns/1ps
module pxser_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_en = 1'b0;
    logic        quad_mode = 1'b0;
    logic [13:0] ch1_word = '0;
    logic [13:0] ch2_word = '0;
    logic [3:0]  lane_bit;
    logic [3:0]  lane_en;
    logic        frame_bit;
    logic        tag_odd;
    logic        bit_strobe;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string phase = "R9";

    always #2 clk = ~clk;

    pxser_top dut_i (
        .clk(clk), .rst(rst), .bit_en(bit_en), .quad_mode(quad_mode),
        .ch1_word(ch1_word), .ch2_word(ch2_word), .lane_bit(lane_bit),
        .lane_en(lane_en), .frame_bit(frame_bit), .tag_odd(tag_odd),
        .bit_strobe(bit_strobe)
    );

    // Behavioural reference: word queue per channel, integer slot position.
    bit        m_idle = 1;
    bit        m_tag = 0;
    bit        m_four = 0;
    bit        m_strobe = 0;
    int        m_pos = 0;
    bit        m_w1[$];
    bit        m_w2[$];

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_idle = 1; m_tag = 0; m_four = 0; m_strobe = 0; m_pos = 0;
            m_w1.delete(); m_w2.delete();
            for (int i = 0; i < 14; i++) begin m_w1.push_back(1'b0); m_w2.push_back(1'b0); end
        end else begin
            m_strobe = bit_en;
            if (bit_en) begin
                if (m_idle || m_pos == (m_four ? 7 : 13)) begin
                    m_w1.delete(); m_w2.delete();
                    for (int b = 13; b >= 0; b--) begin
                        m_w1.push_back(ch1_word[b]);
                        m_w2.push_back(ch2_word[b]);
                    end
                    m_four = quad_mode;
                    m_tag  = !m_tag;
                    m_idle = 0;
                    m_pos  = 0;
                end else begin
                    m_pos++;
                end
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int p;
        bit [3:0] e_lane;
        bit e_frame;
        p = (m_four && m_pos > 6) ? 6 : m_pos;
        if (m_four) begin
            e_lane[1] = m_w1[p];      e_lane[0] = m_w1[p + 7];
            e_lane[2] = m_w2[p];      e_lane[3] = m_w2[p + 7];
        end else begin
            e_lane = {1'b0, m_w2[m_pos], m_w1[m_pos], 1'b0};
        end
        e_frame = !m_idle && (m_pos < (m_tag ? 3 : 2));
        check({phase, m_four ? "/R1" : "/R2"}, "lane_bit", lane_bit, e_lane);
        check({phase, "/R2"}, "lane_en", lane_en, m_four ? 4'b1111 : 4'b0110);
        check({phase, "/R3"}, "frame_bit", frame_bit, e_frame);
        check({phase, "/R4"}, "tag_odd", tag_odd, m_tag);
        check({phase, "/R8"}, "bit_strobe", bit_strobe, m_strobe);
    endtask

    task automatic run(input string ph, input int n, input int en_pct, input bit flip_mode, input bit four);
        phase = ph;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
            bit_en   = ($urandom_range(99) < en_pct);
            ch1_word = 14'($urandom);
            ch2_word = 14'($urandom);
            quad_mode = flip_mode ? 1'($urandom) : four;
        end
    endtask

    initial begin
        // R9: reset values while reset is held and just after release.
        repeat (3) @(negedge clk);
        check("R9", "lane_bit", lane_bit, 0);
        check("R9", "frame_bit", frame_bit, 0);
        check("R9", "tag_odd", tag_odd, 0);
        check("R9", "lane_en", lane_en, 4'b0110);
        check("R9", "bit_strobe", bit_strobe, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        compare_all();
        // Fixed directed word in four-lane mode first: R1 with known bits.
        ch1_word = 14'h2A5B; ch2_word = 14'h1C3E; quad_mode = 1'b1; bit_en = 1'b1;
        run("R1", 200, 100, 0, 1);   // also R5: words change every cycle
        run("R2", 200, 100, 0, 0);
        run("R7", 400, 50, 0, 1);
        run("R7", 400, 50, 0, 0);
        run("R6", 600, 80, 1, 0);    // mode flips mid-word
        run("R5", 400, 100, 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule